// File: doc/BRIEF.md
# Serial register access slave

This block is a byte-wide serial slave framed by a select line. While select is high, each strobe on the link exchanges one byte in each direction. The first bytes of a selection form a header that picks an address space, a direction and a start address. Every byte after that is data, and each data byte moves to the next address.

Two address spaces share the link. A header whose first byte has bit 7 set opens the main space. This space is 16 bits wide, and its accesses go out on a simple single-cycle bus toward the core. A header whose first byte has bit 7 clear opens the command space. This is a small register file held inside the block. It contains a fixed device identifier, an interrupt mask, an interrupt cause register with write-one-to-clear bits, and some general byte storage. The block drives an interrupt output from the cause and mask registers.

Read data is fetched ahead of time, so the byte for the next strobe is already present on the output. Lowering select ends the transaction at any point, and the next selection starts with a new header.

Top module: `sreg_link_slave`

## Requirements
- R1: After reset, tx_byte is 0x00, irq is low, and neither bus_rd nor bus_wr is asserted.
- R2: A header whose first byte has bit 7 set is 4 bytes long. Bit 6 of that first byte selects write (1) or read (0). Header byte 1 is the high byte of the 16-bit main address and header byte 2 is the low byte. Header byte 3 is ignored.
- R3: A header whose first byte has bit 7 clear is 2 bytes long. Bit 6 of that first byte selects write, and bits 5:0 give the command register address. Header byte 1 is ignored.
- R4: A command-space read that starts at address 0x00 returns the device identifier bytes 0x04, 0x02, 0x02, 0x00 in that order. Any further bytes of that read return 0x00.
- R5: Each data byte after the header uses the next address. In the main space the address wraps from 0xFFFF to 0x0000.
- R6: The data for every read byte is on tx_byte before that byte's strobe. bus_rd pulses for one cycle in the cycle after the last header strobe of a main read, and again in the cycle after each data strobe of that read. A main read of N data bytes therefore gives N+1 bus_rd pulses.
- R7: A main-space write drives bus_wr in the cycle of the data strobe, with bus_wdata equal to the received byte and bus_addr equal to the current address. bus_rd and bus_wr are never high together.
- R8: Command register 0x02 is the interrupt mask, and it reads back what was written. irq is high exactly when some bit is set in both the mask and the cause register. Writing 0x00 masks every source and writing 0xF8 enables every source.
- R9: Command register 0x03 is the cause register. A pulse on evt bits 7:3 sets the matching bit, and evt bits 2:0 have no effect. Writing a 1 to a bit clears it and writing a 0 leaves it unchanged. If a set and a clear reach the same bit in the same cycle, the set wins.
- R10: Lowering select aborts the transaction and clears tx_byte to 0x00. The next selection is parsed from a new header, and strobes that arrive while select is low are ignored.
- R11: Command address 0x01 and addresses 0x04 up to CMD_REGS-1 are read/write byte storage. Reads from addresses at or above CMD_REGS return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Transaction select; high frames one transaction |
| rx_vld | input | 1 | Byte strobe, one cycle per byte |
| rx_byte | input | 8 | Byte received from the master |
| tx_byte | output | 8 | Byte returned to the master, sampled at the strobe |
| bus_addr | output | 16 | Main-space address |
| bus_rd | output | 1 | Main-space read pulse |
| bus_rdata | input | 8 | Main-space read data, valid in the bus_rd cycle |
| bus_wr | output | 1 | Main-space write pulse |
| bus_wdata | output | 8 | Main-space write data |
| evt | input | 8 | Interrupt event pulses; bits 7:3 are live |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that two strobes are always at least two cycles apart. This gives every prefetch a free cycle in which to complete. They also assume that the core answers a read in the same cycle as bus_rd. The bench keeps to these limits: each byte task raises rx_vld for one cycle and then holds it low for two. The bus model returns a value computed combinationally from the address. Select only changes at a negedge on which no strobe is being driven.

// File: rtl/sls_pkg.sv
package sls_pkg;
    localparam int MAIN_AW      = 16;
    localparam int CMD_AW       = 6;
    localparam int HDR_SPACE_B  = 7;
    localparam int HDR_WR_B     = 6;
    localparam int MAIN_HDR_LEN = 4;
    localparam int CMD_HDR_LEN  = 2;
    localparam logic [CMD_AW-1:0] CA_ID    = 6'h00;
    localparam logic [CMD_AW-1:0] CA_MASK  = 6'h02;
    localparam logic [CMD_AW-1:0] CA_CAUSE = 6'h03;
    localparam logic [7:0] CAUSE_LIVE = 8'hF8;

    typedef enum logic {PH_HDR, PH_DATA} phase_e;
endpackage

// File: rtl/sls_hdr_parser.sv
module sls_hdr_parser
    import sls_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                rx_vld,
    input  logic [7:0]          rx_byte,
    input  logic [7:0]          main_rdata,
    input  logic [7:0]          cmd_rdata,
    output logic [7:0]          tx_byte,
    output logic [MAIN_AW-1:0]  acc_addr,
    output logic                main_sp,
    output logic                id_mode,
    output logic                rd_fetch,
    output logic                wr_stb
);
    localparam int HCW = $clog2(MAIN_HDR_LEN);

    typedef struct packed {
        phase_e             ph;
        logic [HCW-1:0]     hcnt;
        logic               main;
        logic               wr;
        logic               idm;
        logic [MAIN_AW-1:0] addr;
        logic               fetch;
        logic [7:0]         tx;
    } pst_t;

    pst_t st_d, st_q;
    logic stb, last_hdr;

    always_comb begin
        st_d     = st_q;
        st_d.fetch = 1'b0;
        stb      = sel && rx_vld;
        last_hdr = 1'b0;
        if (!sel) begin
            st_d.ph   = PH_HDR;
            st_d.hcnt = '0;
            st_d.idm  = 1'b0;
            st_d.tx   = 8'h00;
        end else begin
            if (st_q.fetch)
                st_d.tx = st_q.main ? main_rdata : cmd_rdata;
            if (stb && st_q.ph == PH_HDR) begin
                st_d.hcnt = st_q.hcnt + 1'b1;
                if (st_q.hcnt == '0) begin
                    st_d.main = rx_byte[HDR_SPACE_B];
                    st_d.wr   = rx_byte[HDR_WR_B];
                    st_d.addr = '0;
                    if (!rx_byte[HDR_SPACE_B])
                        st_d.addr[CMD_AW-1:0] = rx_byte[CMD_AW-1:0];
                end else if (st_q.main) begin
                    if (st_q.hcnt == HCW'(1)) st_d.addr[MAIN_AW-1:8] = rx_byte;
                    if (st_q.hcnt == HCW'(2)) st_d.addr[7:0] = rx_byte;
                    last_hdr = (st_q.hcnt == HCW'(MAIN_HDR_LEN - 1));
                end else begin
                    last_hdr = (st_q.hcnt == HCW'(CMD_HDR_LEN - 1));
                end
                if (last_hdr) begin
                    st_d.ph    = PH_DATA;
                    st_d.hcnt  = '0;
                    st_d.fetch = !st_q.wr;
                    st_d.idm   = !st_q.main && !st_q.wr && (st_q.addr[CMD_AW-1:0] == CA_ID);
                end
            end else if (stb) begin
                st_d.addr  = st_q.addr + 1'b1;
                st_d.fetch = !st_q.wr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_HDR, hcnt: '0, main: 1'b0, wr: 1'b0, idm: 1'b0,
                      addr: '0, fetch: 1'b0, tx: 8'h00};
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_byte  = st_q.tx;
    assign acc_addr = st_q.addr;
    assign main_sp  = st_q.main;
    assign id_mode  = st_q.idm;
    assign rd_fetch = st_q.fetch && sel;
    assign wr_stb   = stb && st_q.ph == PH_DATA && st_q.wr;

    // R10
    abort_to_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (st_q.ph == PH_HDR && st_q.hcnt == '0 && st_q.tx == 8'h00));
    // R6
    fetch_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fetch |-> $past(rx_vld && sel));
endmodule

// File: rtl/sls_cmd_regs.sv
module sls_cmd_regs
    import sls_pkg::*;
#(
    parameter int          CMD_REGS = 16,
    parameter logic [31:0] DEV_ID   = 32'h04020200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_AW-1:0] addr,
    input  logic              id_mode,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        evt,
    output logic [7:0]        rdata,
    output logic              irq
);
    localparam int RIW = $clog2(CMD_REGS);

    typedef struct packed {
        logic [CMD_REGS-1:0][7:0] gen;
        logic [7:0]               mask;
        logic [7:0]               cause;
    } cst_t;

    cst_t cs_d, cs_q;
    logic in_range;
    logic [7:0] clr;

    assign in_range = addr < CMD_AW'(CMD_REGS);

    always_comb begin
        cs_d = cs_q;
        clr  = 8'h00;
        if (wr_en) begin
            if (addr == CA_MASK)        cs_d.mask = wr_data;
            else if (addr == CA_CAUSE)  clr = wr_data;
            else if (addr != CA_ID && in_range) cs_d.gen[addr[RIW-1:0]] = wr_data;
        end
        cs_d.cause = (cs_q.cause & ~clr) | (evt & CAUSE_LIVE);
    end

    always_comb begin
        rdata = 8'h00;
        if (id_mode) begin
            if (addr < CMD_AW'(4))
                rdata = DEV_ID[(3 - int'(addr[1:0])) * 8 +: 8];
        end else if (addr == CA_MASK) begin
            rdata = cs_q.mask;
        end else if (addr == CA_CAUSE) begin
            rdata = cs_q.cause;
        end else if (addr != CA_ID && in_range) begin
            rdata = cs_q.gen[addr[RIW-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign irq = |(cs_q.cause & cs_q.mask);

    // R8
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CA_MASK) |=> cs_q.mask == $past(wr_data));
    // R9
    cause_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CA_CAUSE && evt == 8'h00) |=> (cs_q.cause & $past(wr_data)) == 8'h00);
    // R9
    cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & CAUSE_LIVE) != 8'h00 |=> (cs_q.cause & $past(evt & CAUSE_LIVE)) == $past(evt & CAUSE_LIVE));
endmodule

// File: rtl/sreg_link_slave.sv
module sreg_link_slave
    import sls_pkg::*;
#(
    parameter int          CMD_REGS = 16,
    parameter logic [31:0] DEV_ID   = 32'h04020200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               rx_vld,
    input  logic [7:0]         rx_byte,
    output logic [7:0]         tx_byte,
    output logic [MAIN_AW-1:0] bus_addr,
    output logic               bus_rd,
    input  logic [7:0]         bus_rdata,
    output logic               bus_wr,
    output logic [7:0]         bus_wdata,
    input  logic [7:0]         evt,
    output logic               irq
);
    logic [MAIN_AW-1:0] acc_addr;
    logic main_sp, id_mode, rd_fetch, wr_stb;
    logic [7:0] cmd_rdata;

    sls_hdr_parser u_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .rx_vld     (rx_vld),
        .rx_byte    (rx_byte),
        .main_rdata (bus_rdata),
        .cmd_rdata  (cmd_rdata),
        .tx_byte    (tx_byte),
        .acc_addr   (acc_addr),
        .main_sp    (main_sp),
        .id_mode    (id_mode),
        .rd_fetch   (rd_fetch),
        .wr_stb     (wr_stb)
    );

    sls_cmd_regs #(.CMD_REGS(CMD_REGS), .DEV_ID(DEV_ID)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (acc_addr[CMD_AW-1:0]),
        .id_mode (id_mode),
        .wr_en   (wr_stb && !main_sp),
        .wr_data (rx_byte),
        .evt     (evt),
        .rdata   (cmd_rdata),
        .irq     (irq)
    );

    assign bus_addr  = acc_addr;
    assign bus_rd    = rd_fetch && main_sp;
    assign bus_wr    = wr_stb && main_sp;
    assign bus_wdata = rx_byte;

    // R7
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr}));
    // R7
    wr_in_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (sel && rx_vld && bus_wdata == rx_byte));
endmodule

// File: tb/sreg_link_slave_test.sv
module sreg_link_slave_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, rx_vld = 1'b0;
    logic [7:0] rx_byte = 8'h00, evt = 8'h00;
    logic [7:0] tx_byte, bus_rdata, bus_wdata;
    logic [15:0] bus_addr;
    logic bus_rd, bus_wr, irq;

    int n_chk = 0, n_bad = 0, rd_cnt = 0, wn = 0;
    logic [7:0]  mem [256];
    logic [15:0] wa [16];
    logic [7:0]  wd [16];
    bit done = 0;

    always #10 clk = ~clk;

    sreg_link_slave uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .tx_byte(tx_byte), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .evt(evt), .irq(irq)
    );

    assign bus_rdata = mem[bus_addr[7:0]] ^ bus_addr[15:8];

    always @(posedge clk) begin
        if (bus_rd) rd_cnt <= rd_cnt + 1;
        if (bus_wr) begin
            mem[bus_addr[7:0]] <= bus_wdata;
            if (wn < 16) begin wa[wn] <= bus_addr; wd[wn] <= bus_wdata; end
            wn <= wn + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] got);
        @(negedge clk); rx_vld = 1'b1; rx_byte = b; got = tx_byte;
        @(negedge clk); rx_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic open_t;
        @(negedge clk); sel = 1'b1;
    endtask

    task automatic close_t;
        @(negedge clk); sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic cmd_write(input logic [5:0] a, input logic [7:0] v);
        logic [7:0] g;
        open_t; xfer({2'b01, a}, g); xfer(8'h00, g); xfer(v, g); close_t;
    endtask

    task automatic cmd_read(input logic [5:0] a, output logic [7:0] v);
        logic [7:0] g;
        open_t; xfer({2'b00, a}, g); xfer(8'h00, g); xfer(8'h00, v); close_t;
    endtask

    task automatic t_reset;
        check("R1 tx_byte", tx_byte, 8'h00);
        check("R1 irq", irq, 1'b0);
        check("R1 bus strobes", {bus_rd, bus_wr}, 2'b00);
    endtask

    task automatic t_devid;
        logic [7:0] g;
        logic [7:0] ev [5] = '{8'h04, 8'h02, 8'h02, 8'h00, 8'h00};
        open_t; xfer(8'h00, g); xfer(8'h00, g);
        for (int i = 0; i < 5; i++) begin
            xfer(8'h00, g);
            check($sformatf("R4 R3 id byte %0d", i), g, ev[i]);
        end
        close_t;
    endtask

    task automatic t_main_write;
        logic [7:0] g;
        int w0 = wn;
        open_t; xfer(8'hC0, g); xfer(8'h12, g); xfer(8'h34, g); xfer(8'h99, g);
        xfer(8'hA1, g); xfer(8'hA2, g); xfer(8'hA3, g);
        close_t;
        check("R7 write count", wn - w0, 3);
        for (int i = 0; i < 3; i++) begin
            check($sformatf("R2 R5 write addr %0d", i), wa[w0 + i], 16'h1234 + 16'(i));
            check($sformatf("R7 write data %0d", i), wd[w0 + i], 8'hA1 + 8'(i));
        end
    endtask

    task automatic t_main_read;
        logic [7:0] g;
        int r0 = rd_cnt;
        open_t; xfer(8'h80, g); xfer(8'h12, g); xfer(8'h34, g); xfer(8'h5A, g);
        for (int i = 0; i < 3; i++) begin
            xfer(8'h00, g);
            check($sformatf("R2 R6 read byte %0d", i), g, (8'hA1 + 8'(i)) ^ 8'h12);
        end
        close_t;
        check("R6 bus_rd pulses", rd_cnt - r0, 4);
    endtask

    task automatic t_wrap;
        logic [7:0] g;
        int w0 = wn;
        open_t; xfer(8'hC0, g); xfer(8'hFF, g); xfer(8'hFF, g); xfer(8'h00, g);
        xfer(8'h3C, g); xfer(8'h3D, g);
        close_t;
        check("R5 wrap addr0", wa[w0], 16'hFFFF);
        check("R5 wrap addr1", wa[w0 + 1], 16'h0000);
    endtask

    task automatic t_cmd_store;
        logic [7:0] g, v;
        open_t; xfer(8'h44, g); xfer(8'h00, g); xfer(8'h5A, g); xfer(8'h6B, g); close_t;
        open_t; xfer(8'h04, g); xfer(8'h00, g);
        xfer(8'h00, v); check("R11 R5 reg4", v, 8'h5A);
        xfer(8'h00, v); check("R11 R5 reg5", v, 8'h6B);
        close_t;
        cmd_write(6'h01, 8'hC3);
        cmd_read(6'h01, v); check("R11 reg1", v, 8'hC3);
        cmd_read(6'h14, v); check("R11 out of range", v, 8'h00);
    endtask

    task automatic pulse_evt(input logic [7:0] e);
        @(negedge clk); evt = e;
        @(negedge clk); evt = 8'h00;
    endtask

    task automatic t_irq;
        logic [7:0] v;
        cmd_write(6'h02, 8'hF8);
        cmd_read(6'h02, v); check("R8 mask readback", v, 8'hF8);
        check("R8 irq no cause", irq, 1'b0);
        pulse_evt(8'h08);
        check("R8 irq raised", irq, 1'b1);
        pulse_evt(8'h07);
        cmd_read(6'h03, v); check("R9 dead bits ignored", v, 8'h08);
        cmd_write(6'h02, 8'h00);
        check("R8 masked all", irq, 1'b0);
        cmd_write(6'h02, 8'hF8);
        cmd_write(6'h03, 8'h00);
        cmd_read(6'h03, v); check("R9 zero write keeps", v, 8'h08);
        cmd_write(6'h03, 8'h08);
        cmd_read(6'h03, v); check("R9 one clears", v, 8'h00);
        check("R8 irq after clear", irq, 1'b0);
    endtask

    task automatic t_abort;
        logic [7:0] g, v;
        int w0 = wn;
        open_t; xfer(8'hC0, g); xfer(8'h12, g); close_t;
        check("R10 tx cleared", tx_byte, 8'h00);
        @(negedge clk); rx_vld = 1'b1; rx_byte = 8'h44;
        @(negedge clk); rx_vld = 1'b0;
        @(negedge clk); rx_vld = 1'b1; rx_byte = 8'hEE;
        @(negedge clk); rx_vld = 1'b0;
        open_t; xfer(8'h00, g); xfer(8'h00, g); xfer(8'h00, v); close_t;
        check("R10 fresh header id", v, 8'h04);
        cmd_read(6'h04, v); check("R10 strobes ignored", v, 8'h5A);
        check("R10 no bus write", wn - w0, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 3 + 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_devid;
        t_main_write;
        t_main_read;
        t_wrap;
        t_cmd_store;
        t_irq;
        t_abort;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule